// File: doc/BRIEF.md
# Byte-FIFO SPI Master with Register Interface

This block is a register-mapped SPI master. Software writes bytes through a data register into a 64-entry transmit FIFO. A shift engine exchanges each byte full duplex on the serial pins and stores the byte it receives in a 64-entry receive FIFO. Software then pops those bytes through the same data register. A control/status word holds the transfer-active gate, two interrupt enables and self-clearing FIFO flush bits. The same word also carries five read-only status flags that are recomputed every cycle from the FIFO occupancies and the engine state. One level-sensitive interrupt line reports completion or a receive FIFO that is filling up.

The shift engine is a four-state machine. ENG_IDLE waits for a start, which needs transfer-active set, a non-empty TX FIFO and room in the RX FIFO. On a start it pops the TX head and moves to ENG_SETUP, where SCLK is low and MOSI shows the current bit. When the half-period timer expires, ENG_SETUP goes to ENG_HOLD and MISO is sampled on the rising SCLK. When the timer expires in ENG_HOLD, the engine shifts at the falling SCLK. It returns to ENG_SETUP if bits remain, or goes to ENG_PUSH after the eighth bit. ENG_PUSH writes the received byte into the RX FIFO and returns to ENG_IDLE. The serial mode is SPI mode 0, MSB first.

Registers sit at word offsets on a 32-bit bus. Reads are combinational and writes take effect at the clock edge.
- 0x00: control/status.
- 0x04: data.
- 0x08: clock divider, 16 bits.
- 0x0C: transfer length, 16 bits, stored only.
- 0x10: hold delay, 4 bits, stored only.
- 0x14: DMA thresholds, 32 bits, stored only.

Top module: `spi_master_regs`

## Requirements
- R1: After reset, the registers read as follows: control/status 0x00041000, divider 0, length 0, hold 0x1, thresholds 0x30201020. After reset irq is 0, cs_n is 1 and sclk is 0.
- R2: Control/status bits 20..16 are read-only status and ignore writes. Bits 5 (flush RX) and 4 (flush TX) act on the write and read back as 0. Every other bit stores the written value. Bit 7 is transfer-active, bit 9 enables the done interrupt, bit 10 enables the RX-high interrupt and bit 12 is read-enable.
- R3: A write to offset 0x04 while bit 7 is 1 pushes the low byte into the TX FIFO if the FIFO is not full. While bit 7 is 0, such a write has no effect.
- R4: Each byte is exchanged full duplex in SPI mode 0, MSB first. MOSI changes only while SCLK is low and MISO is sampled on the rising SCLK. The received byte is pushed into the RX FIFO.
- R5: Each SCLK half period lasts exactly as many clock cycles as the divider value. A divider of 0 gives 65536 cycles.
- R6: A read of offset 0x04 returns and pops the oldest RX byte if the RX FIFO is not empty. Otherwise it returns 0 and changes nothing.
- R7: Status flags: bit 20 is 1 when the RX FIFO holds 64 bytes. Bit 19 is 1 when transfer-active is 1 and the RX FIFO holds 48 or more bytes. Bit 18 is 1 when the TX FIFO is not full. Bit 17 is 1 when the RX FIFO is not empty.
- R8: Bit 16 (done) is 1 exactly when transfer-active is 1, the TX FIFO is empty and no byte is in flight. Writing transfer-active as 0 therefore clears it.
- R9: Writing bit 5 or bit 4 as 1 empties the RX or TX FIFO, and the flags follow in the next cycle.
- R10: No byte exchange starts while the RX FIFO is full. Pending TX bytes wait.
- R11: irq = (bit 9 AND done) OR (bit 10 AND bit 19).
- R12: cs_n is 0 while transfer-active is 1 or a byte is in flight. SCLK toggles only while cs_n is 0.
- R13: Unaligned offsets and offsets 0x18 and above read 0 and ignore writes. The divider and length keep only bits 15..0, and the hold delay keeps only bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (pops RX on the data offset) |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Level interrupt |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The assertions check the following on every cycle:
- SCLK never pulses with chip select high.
- MOSI holds steady through each high SCLK phase.
- A received byte is only pushed after a high phase, and never into a full RX FIFO.
- A flush empties a FIFO, and popping an empty FIFO does nothing.
- Data writes made with transfer-active low leave the TX occupancy untouched.

The bench scenarios are needed for the rest:
- the byte values on both serial lines;
- the exact SCLK half-period length;
- the flag words at the 48 and 64 byte boundaries;
- the stall behind a full RX FIFO;
- the interrupt combinations;
- the register masking and reset values.

// File: rtl/spim_pkg.sv
package spim_pkg;
    // control/status bit positions (software decodes these)
    localparam int ST_RX_FULL  = 20;
    localparam int ST_RX_HIGH  = 19;
    localparam int ST_TX_ROOM  = 18;
    localparam int ST_RX_AVAIL = 17;
    localparam int ST_DONE     = 16;
    localparam int CF_IE_HIGH  = 10;
    localparam int CF_IE_DONE  = 9;
    localparam int CF_ACTIVE   = 7;
    localparam int CF_CLR_RX   = 5;
    localparam int CF_CLR_TX   = 4;

    localparam logic [31:0] RO_MASK   = 32'h001F_0000;
    localparam logic [31:0] CLR_MASK  = 32'h0000_0030;
    localparam logic [31:0] CTRL_RST  = 32'h0000_1000;
    localparam logic [3:0]  HOLD_RST  = 4'h1;
    localparam logic [31:0] THR_RST   = 32'h3020_1020;

    // word index of each register
    localparam logic [2:0] REG_CTRL = 3'd0;
    localparam logic [2:0] REG_DATA = 3'd1;
    localparam logic [2:0] REG_DIV  = 3'd2;
    localparam logic [2:0] REG_LEN  = 3'd3;
    localparam logic [2:0] REG_HOLD = 3'd4;
    localparam logic [2:0] REG_THR  = 3'd5;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SETUP,
        ENG_HOLD,
        ENG_PUSH
    } eng_state_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign do_push = push && (count != FULL_CNT);
    assign do_pop  = pop && (count != '0);
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= wdata;
    end

    // R9
    fifo_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R6
    fifo_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == '0 && !push && !clr) |=> (count == '0));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int DIV_W = 16,
    localparam int TW = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       tx_byte,
    input  logic [DIV_W-1:0] divider,
    input  logic             miso,
    output logic             pop_tx,
    output logic             rx_push,
    output logic [7:0]       rx_byte,
    output logic             busy,
    output logic             sclk,
    output logic             mosi
);
    eng_state_t state, nxt;
    logic [TW-1:0] timer, half;
    logic [2:0]    bitn;
    logic [7:0]    shreg;
    logic          samp;
    logic          tick;

    assign half = (divider == '0) ? (TW'(1) << DIV_W) : {1'b0, divider};
    assign tick = (timer == TW'(1));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ENG_IDLE:  if (start) nxt = ENG_SETUP;
            ENG_SETUP: if (tick)  nxt = ENG_HOLD;
            ENG_HOLD:  if (tick)  nxt = (bitn == 3'd0) ? ENG_PUSH : ENG_SETUP;
            ENG_PUSH:  nxt = ENG_IDLE;
            default:   nxt = ENG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer <= '0;
            bitn  <= '0;
            shreg <= '0;
            samp  <= 1'b0;
        end else begin
            unique case (state)
                ENG_IDLE: if (start) begin
                    shreg <= tx_byte;
                    bitn  <= 3'd7;
                    timer <= half;
                end
                ENG_SETUP: if (tick) begin
                    samp  <= miso;
                    timer <= half;
                end else begin
                    timer <= timer - 1'b1;
                end
                ENG_HOLD: if (tick) begin
                    shreg <= {shreg[6:0], samp};
                    timer <= half;
                    bitn  <= bitn - 1'b1;
                end else begin
                    timer <= timer - 1'b1;
                end
                ENG_PUSH: timer <= '0;
                default:  timer <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        sclk    = (state == ENG_HOLD);
        mosi    = shreg[7];
        busy    = (state != ENG_IDLE);
        pop_tx  = (state == ENG_IDLE) && start;
        rx_push = (state == ENG_PUSH);
        rx_byte = shreg;
    end

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_HOLD && $past(state) == ENG_HOLD) |-> $stable(mosi));

    // R4
    push_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> ($past(state) == ENG_HOLD));
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int DIV_W      = 16,
    parameter int ADDR_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int CW        = $clog2(FIFO_DEPTH + 1);
    localparam int HIGH_MARK = (FIFO_DEPTH * 3) / 4;
    localparam logic [CW-1:0] FULL_CNT = CW'(FIFO_DEPTH);
    localparam logic [CW-1:0] HIGH_CNT = CW'(HIGH_MARK);

    logic [31:0]      ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic [15:0]      len_q;
    logic [3:0]       hold_q;
    logic [31:0]      thr_q;

    logic [2:0]    idx;
    logic          aligned, in_map;
    logic          wr_ctrl, wr_data, rd_data;
    logic          ta, clr_rx, clr_tx;
    logic          tx_push, rx_pop;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [7:0]    tx_head, rx_head, eng_rx_byte;
    logic          eng_pop, eng_push, eng_busy, eng_start;
    logic          f_rx_full, f_rx_high, f_tx_room, f_rx_avail, f_done;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign in_map  = aligned && (idx <= REG_THR);
    assign wr_ctrl = bus_wr && in_map && (idx == REG_CTRL);
    assign wr_data = bus_wr && in_map && (idx == REG_DATA);
    assign rd_data = bus_rd && in_map && (idx == REG_DATA);

    assign ta      = ctrl_q[CF_ACTIVE];
    assign clr_rx  = wr_ctrl && bus_wdata[CF_CLR_RX];
    assign clr_tx  = wr_ctrl && bus_wdata[CF_CLR_TX];
    assign tx_push = wr_data && ta && (tx_cnt != FULL_CNT);
    assign rx_pop  = rd_data && (rx_cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            div_q  <= '0;
            len_q  <= '0;
            hold_q <= HOLD_RST;
            thr_q  <= THR_RST;
        end else if (bus_wr && in_map) begin
            unique case (idx)
                REG_CTRL: ctrl_q <= bus_wdata & ~(RO_MASK | CLR_MASK);
                REG_DIV:  div_q  <= bus_wdata[DIV_W-1:0];
                REG_LEN:  len_q  <= bus_wdata[15:0];
                REG_HOLD: hold_q <= bus_wdata[3:0];
                REG_THR:  thr_q  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(clr_tx),
        .push(tx_push), .wdata(bus_wdata[7:0]),
        .pop(eng_pop), .rdata(tx_head), .count(tx_cnt)
    );

    spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(clr_rx),
        .push(eng_push), .wdata(eng_rx_byte),
        .pop(rx_pop), .rdata(rx_head), .count(rx_cnt)
    );

    assign eng_start = ta && (tx_cnt != '0) && (rx_cnt != FULL_CNT);

    spim_shifter #(.DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(tx_head),
        .divider(div_q), .miso(miso), .pop_tx(eng_pop), .rx_push(eng_push),
        .rx_byte(eng_rx_byte), .busy(eng_busy), .sclk(sclk), .mosi(mosi)
    );

    // status flags, recomputed from occupancy every cycle
    always_comb begin
        f_rx_full  = (rx_cnt == FULL_CNT);
        f_rx_high  = ta && (rx_cnt >= HIGH_CNT);
        f_tx_room  = (tx_cnt != FULL_CNT);
        f_rx_avail = (rx_cnt != '0);
        f_done     = ta && (tx_cnt == '0) && !eng_busy;
    end

    assign irq  = (ctrl_q[CF_IE_DONE] && f_done) || (ctrl_q[CF_IE_HIGH] && f_rx_high);
    assign cs_n = !(ta || eng_busy);

    always_comb begin
        bus_rdata = '0;
        if (in_map) begin
            unique case (idx)
                REG_CTRL: begin
                    bus_rdata              = ctrl_q;
                    bus_rdata[ST_RX_FULL]  = f_rx_full;
                    bus_rdata[ST_RX_HIGH]  = f_rx_high;
                    bus_rdata[ST_TX_ROOM]  = f_tx_room;
                    bus_rdata[ST_RX_AVAIL] = f_rx_avail;
                    bus_rdata[ST_DONE]     = f_done;
                end
                REG_DATA: bus_rdata = f_rx_avail ? {24'b0, rx_head} : 32'b0;
                REG_DIV:  bus_rdata = 32'(div_q);
                REG_LEN:  bus_rdata = {16'b0, len_q};
                REG_HOLD: bus_rdata = {28'b0, hold_q};
                REG_THR:  bus_rdata = thr_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R12
    sclk_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R3
    idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !ta && !clr_tx) |=> $stable(tx_cnt));

    // R10
    rx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_push |-> (rx_cnt != FULL_CNT));
endmodule

// File: tb/tb_spi_master_regs.sv
module tb_spi_master_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq, sclk, mosi, miso, cs_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    spi_master_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    function automatic logic [7:0] resp(input int k);
        return 8'(k * 37 + 5);
    endfunction

    // SPI slave model, mode 0
    logic [7:0] slv_sh, slv_in;
    logic [7:0] slv_log [256];
    int slv_bits = 0;
    int slv_cnt = 0;
    initial begin
        slv_sh = resp(0);
        slv_in = '0;
    end
    always @(posedge sclk) begin
        slv_in = {slv_in[6:0], mosi};
        slv_bits++;
    end
    always @(negedge sclk) begin
        if (slv_bits == 8) begin
            slv_log[slv_cnt[7:0]] = slv_in;
            slv_cnt++;
            slv_bits = 0;
            slv_sh = resp(slv_cnt);
        end else begin
            slv_sh = slv_sh << 1;
        end
    end
    assign miso = slv_sh[7];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // {write, addr, data, expected}
    localparam int NV = 19;
    localparam logic [69:0] VEC [NV] = '{
        {1'b0, 5'h08, 32'h0,          32'h0},
        {1'b0, 5'h0C, 32'h0,          32'h0},
        {1'b0, 5'h10, 32'h0,          32'h1},
        {1'b0, 5'h14, 32'h0,          32'h3020_1020},
        {1'b0, 5'h00, 32'h0,          32'h0004_1000},
        {1'b1, 5'h08, 32'h0001_2345,  32'h0},
        {1'b0, 5'h08, 32'h0,          32'h0000_2345},
        {1'b1, 5'h0C, 32'hFFFF_ABCD,  32'h0},
        {1'b0, 5'h0C, 32'h0,          32'h0000_ABCD},
        {1'b1, 5'h10, 32'h0000_00FE,  32'h0},
        {1'b0, 5'h10, 32'h0,          32'h0000_000E},
        {1'b1, 5'h14, 32'hDEAD_BEEF,  32'h0},
        {1'b0, 5'h14, 32'h0,          32'hDEAD_BEEF},
        {1'b1, 5'h18, 32'hFFFF_FFFF,  32'h0},
        {1'b0, 5'h18, 32'h0,          32'h0},
        {1'b1, 5'h00, 32'hFFE0_0630,  32'h0},
        {1'b0, 5'h00, 32'h0,          32'hFFE4_0600},
        {1'b1, 5'h00, 32'h0000_1000,  32'h0},
        {1'b1, 5'h08, 32'h0000_0002,  32'h0}
    };

    initial begin
        logic [31:0] rd;
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset pin state
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 cs_n", 32'(cs_n), 32'd1);
        chk("R1 sclk", 32'(sclk), 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [69:0] v;
            v = VEC[i];
            if (v[69]) begin
                bwr(v[68:64], v[63:32]);
            end else begin
                brd(v[68:64], rd);
                if (i < 5)                chk("R1 reset value", rd, v[31:0]);
                else if (v[68:64] == 5'h0) chk("R2 ctrl masking", rd, v[31:0]);
                else                      chk("R13 field width/undefined", rd, v[31:0]);
            end
        end
        bwr(5'h01, 32'h1234);            // unaligned write
        brd(5'h01, rd);
        chk("R13 unaligned", rd, 32'h0);

        // R3: data write ignored with transfer-active low
        bwr(5'h04, 32'h55);
        bwr(5'h00, 32'h1080);
        repeat (40) @(negedge clk);
        brd(5'h00, rd);
        chk("R3/R8 idle write ignored, done", rd, 32'h0005_1080);
        chk("R3 no exchange", 32'(slv_cnt), 32'd0);
        chk("R12 cs_n low when active", 32'(cs_n), 32'd0);

        // R4/R6 exchange of three bytes
        bwr(5'h04, 32'h3C);
        bwr(5'h04, 32'hFFFF_FF81);
        bwr(5'h04, 32'hF0);
        repeat (200) @(negedge clk);
        brd(5'h00, rd);
        chk("R7/R8 after exchange", rd, 32'h0007_1080);
        chk("R11 no enables", 32'(irq), 32'd0);
        chk("R4 mosi byte0", 32'(slv_log[0]), 32'h3C);
        chk("R4 mosi byte1", 32'(slv_log[1]), 32'h81);
        chk("R4 mosi byte2", 32'(slv_log[2]), 32'hF0);
        for (int k = 0; k < 3; k++) begin
            brd(5'h04, rd);
            chk("R4/R6 rx byte", rd, 32'(resp(k)));
        end
        brd(5'h04, rd);
        chk("R6 empty read", rd, 32'h0);
        bwr(5'h00, 32'h1280);
        @(negedge clk);
        chk("R11 done irq", 32'(irq), 32'd1);
        bwr(5'h00, 32'h1200);
        @(negedge clk);
        chk("R11 irq drops", 32'(irq), 32'd0);
        brd(5'h00, rd);
        chk("R8 done cleared", rd, 32'h0004_1200);
        chk("R12 cs_n idle", 32'(cs_n), 32'd1);

        // R5 half-period length with divider 3
        bwr(5'h08, 32'h3);
        bwr(5'h00, 32'h1080);
        bwr(5'h04, 32'h00);
        begin
            int n;
            n = 0;
            @(posedge sclk);
            forever begin
                @(posedge clk);
                #1 n++;
                if (!sclk) break;
            end
            chk("R5 sclk high cycles", 32'(n), 32'd3);
        end
        repeat (200) @(negedge clk);
        brd(5'h04, rd);
        chk("R4 rx byte3", rd, 32'(resp(3)));
        bwr(5'h00, 32'h1000);

        // R7/R9/R10 receive FIFO filling
        bwr(5'h08, 32'h1);
        bwr(5'h00, 32'h1480);
        for (int i = 0; i < 64; i++) bwr(5'h04, 32'(i));
        repeat (1500) @(negedge clk);
        chk("R10 exchanged count", 32'(slv_cnt), 32'd68);
        bad = 0;
        for (int i = 0; i < 64; i++) if (slv_log[4 + i] !== 8'(i)) bad++;
        chk("R4 mosi stream", 32'(bad), 32'd0);
        for (int i = 0; i < 65; i++) bwr(5'h04, 32'hC0 + 32'(i));
        repeat (100) @(negedge clk);
        chk("R10 stalled while RX full", 32'(slv_cnt), 32'd68);
        brd(5'h00, rd);
        chk("R7 full flags", rd, 32'h001A_1480);
        chk("R11 rx-high irq", 32'(irq), 32'd1);
        bwr(5'h00, 32'h1490);
        brd(5'h00, rd);
        chk("R9 flush TX", rd, 32'h001F_1480);
        bad = 0;
        for (int k = 0; k < 16; k++) begin
            brd(5'h04, rd);
            if (rd !== 32'(resp(4 + k))) bad++;
        end
        chk("R6 rx stream", 32'(bad), 32'd0);
        brd(5'h00, rd);
        chk("R7 at 48", rd, 32'h000F_1480);
        brd(5'h04, rd);
        chk("R6 rx byte 20", rd, 32'(resp(20)));
        brd(5'h00, rd);
        chk("R7 at 47", rd, 32'h0007_1480);
        chk("R11 irq low below mark", 32'(irq), 32'd0);
        bwr(5'h00, 32'h14A0);
        brd(5'h00, rd);
        chk("R9 flush RX", rd, 32'h0005_1480);
        brd(5'h04, rd);
        chk("R6 read after flush", rd, 32'h0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule